// File: doc/BRIEF.md
# Programmable Frame Sync Pulse Generator

This block produces the frame-synchronization level for a serial port. All timing is counted in bit-clock cycles. A bit-clock cycle is a system-clock cycle in which a one-cycle bit-clock enable is high. Two down-counters set the timing. The interval counter sets the time between pulse starts, and the length counter sets how long each pulse stays high. Both fields use value-plus-one encoding, so a field value of zero still gives one cycle.

In internal mode, pulses repeat at the programmed interval. In external mode, the interval field is ignored. Instead, the block synchronizes an outside frame signal into the system clock domain and samples it on bit-clock cycles. Each rising edge it sees starts a new pulse.

The pulse length should be kept shorter than the serial word length. The block does not check this.

Top module: `fsync_gen`

## Requirements
- R1: After reset, `fsOut` is low. In internal mode, the first bit-clock cycle after reset starts a pulse.
- R2: In internal mode, consecutive pulse starts are `perField + 1` bit-clock cycles apart, for any `perField` from 0 to 4095.
- R3: Each pulse stays high for `widField + 1` bit-clock cycles, for any `widField` from 0 to 255.
- R4: `fsOut` and both counters change only on cycles where `bitEn` is high. On all other cycles they hold their value.
- R5: When `widField >= perField` in internal mode, `fsOut` stays high without a gap. This includes `perField = 0`, where every bit-clock cycle starts a pulse.
- R6: With `extMode = 1`, `perField` has no effect. A new pulse starts only on a bit-clock cycle where the synchronized `extFs` is high and was low at the previous bit-clock cycle.
- R7: In external mode, a new rising edge seen while a pulse is active restarts that pulse. The output then stays high for a full `widField + 1` cycles counted from the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle bit-clock enable |
| perField | input | 12 | Interval between pulse starts, minus one |
| widField | input | 8 | Pulse length, minus one |
| extMode | input | 1 | 1 = pulses are started by `extFs` |
| extFs | input | 1 | Outside frame signal, asynchronous to `clk` |
| fsOut | output | 1 | Frame-sync level |

## Verification
Two events can fall on the same bit-clock cycle: the end of the current pulse and the start of the next one. When that happens, the start wins. In internal mode, setting `widField` equal to `perField` makes the length counter expire on exactly the cycle the interval counter reloads. The output is judged by checking that `fsOut` never drops after any bit-clock cycle. In external mode, the same overlap is forced by a second rising edge in the middle of a pulse. The check is that the low level arrives `widField + 1` cycles after the second start, not after the first.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // Strobes from the control unit to the pulse datapath
  typedef struct packed {
    logic tick;   // bit-clock cycle
    logic start;  // a pulse begins on this bit-clock cycle
  } fsgStrobe_t;
endpackage

// File: rtl/fsg_sync.sv
module fsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [PER_W-1:0] perField,
  input  logic             extMode,
  input  logic             extSync,
  output fsgStrobe_t       strb
);
  logic [PER_W-1:0] perCnt;
  logic             prevSamp;
  logic             extRise;
  logic             intExpire;

  assign extRise   = extSync & ~prevSamp;
  assign intExpire = (perCnt == '0);

  always_comb begin
    strb.tick  = bitEn;
    strb.start = bitEn & (extMode ? extRise : intExpire);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perCnt   <= '0;
      prevSamp <= 1'b0;
    end else if (bitEn) begin
      prevSamp <= extSync;
      if (strb.start)    perCnt <= perField;
      else if (!extMode) perCnt <= perCnt - 1'b1;
    end
  end

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && !extMode) |=> (perCnt == $past(perField)));

  // R4
  per_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(perCnt));

  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && bitEn && !strb.start) |=> $stable(perCnt));
endmodule

// File: rtl/fsg_dp.sv
module fsg_dp
  import fsg_pkg::*;
#(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsgStrobe_t       strb,
  input  logic [WID_W-1:0] widField,
  output logic             fsOut
);
  logic [WID_W-1:0] widCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widCnt <= '0;
      fsOut  <= 1'b0;
    end else if (strb.tick) begin
      if (strb.start) begin
        fsOut  <= 1'b1;
        widCnt <= widField;
      end else if (fsOut) begin
        if (widCnt == '0) fsOut  <= 1'b0;
        else              widCnt <= widCnt - 1'b1;
      end
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> ($stable(fsOut) && $stable(widCnt)));

  // R3
  start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> fsOut);

  // R3
  fall_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fsOut) |-> ($past(widCnt) == '0));
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsg_pkg::*;
#(
  parameter int PER_W       = 12,
  parameter int WID_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [PER_W-1:0] perField,
  input  logic [WID_W-1:0] widField,
  input  logic             extMode,
  input  logic             extFs,
  output logic             fsOut
);
  logic       extSync;
  fsgStrobe_t strb;

  fsg_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din(extFs), .dout(extSync));

  fsg_ctrl #(.PER_W(PER_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .perField(perField),
    .extMode(extMode), .extSync(extSync), .strb(strb));

  fsg_dp #(.WID_W(WID_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .widField(widField), .fsOut(fsOut));
endmodule

// File: tb/tb_fsync_gen.sv
module tb_fsync_gen;
  logic        clk = 1'b0;
  logic        rstN;
  logic        bitEn;
  logic [11:0] perField;
  logic [7:0]  widField;
  logic        extMode;
  logic        extFs;
  logic        fsOut;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  fsync_gen dut (.clk(clk), .rstN(rstN), .bitEn(bitEn), .perField(perField),
    .widField(widField), .extMode(extMode), .extFs(extFs), .fsOut(fsOut));

  // {perField, widField}
  localparam logic [19:0] VEC [8] = '{
    {12'd15, 8'd1}, {12'd3, 8'd0}, {12'd0, 8'd0}, {12'd2, 8'd5},
    {12'd4, 8'd4}, {12'd7, 8'd3}, {12'd1, 8'd0}, {12'd4095, 8'd255}};

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; bitEn = 1'b0; extFs = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic bitTick();
    @(negedge clk) bitEn = 1'b1;
    @(negedge clk) bitEn = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    perField = 12'd15; widField = 8'd1; extMode = 1'b0;
    doReset();
    // R1: reset level, holds without enables
    chk("R1 reset level", fsOut, 1'b0);
    repeat (5) @(negedge clk);
    chk("R4 idle after reset", fsOut, 1'b0);

    // Table walk: bit-clock n after reset is high iff n mod (P+1) <= W
    for (int v = 0; v < 8; v++) begin
      int p, w, runs;
      p = int'(VEC[v][19:8]);
      w = int'(VEC[v][7:0]);
      perField = VEC[v][19:8];
      widField = VEC[v][7:0];
      doReset();
      runs = 2 * (p + 1) + 3;
      for (int n = 0; n < runs; n++) begin
        logic exp;
        exp = ((n % (p + 1)) <= w);
        bitTick();
        if (n == 0) chk("R1 first start", fsOut, 1'b1);
        else if (w >= p) chk("R5 continuous", fsOut, exp);
        else if ((n % (p + 1)) == 0) chk("R2 period start", fsOut, exp);
        else chk("R3 pulse width", fsOut, exp);
        if (n < 12) begin
          repeat (2) @(negedge clk);
          chk("R4 hold between enables", fsOut, exp);
        end
      end
    end

    // External mode: perField = 3 must not matter
    perField = 12'd3; widField = 8'd2; extMode = 1'b1;
    doReset();
    bitTick(); chk("R6 no start without edge", fsOut, 1'b0);
    bitTick(); chk("R6 no start without edge", fsOut, 1'b0);
    extFs = 1'b1; repeat (3) @(negedge clk);
    for (int n = 0; n < 11; n++) begin
      bitTick();
      chk("R6 ext pulse, period ignored", fsOut, (n <= 2) ? 1'b1 : 1'b0);
    end
    extFs = 1'b0; repeat (3) @(negedge clk);
    bitTick(); chk("R6 low input no start", fsOut, 1'b0);
    widField = 8'd4;
    extFs = 1'b1; repeat (3) @(negedge clk);
    bitTick(); chk("R6 second edge start", fsOut, 1'b1);
    bitTick(); chk("R3 ext width", fsOut, 1'b1);
    extFs = 1'b0; repeat (3) @(negedge clk);
    bitTick(); chk("R3 ext width", fsOut, 1'b1);
    extFs = 1'b1; repeat (3) @(negedge clk);
    // restart at index 3, so high through index 7, low at 8
    for (int n = 3; n < 10; n++) begin
      bitTick();
      chk("R7 restart mid pulse", fsOut, (n <= 7) ? 1'b1 : 1'b0);
    end

    report();
  end
endmodule